// File: doc/BRIEF.md
# CRTC raster timing generator

This block produces the horizontal and vertical raster timing for a single display pipe. A pixel counter runs across each scan line and a line counter runs down each frame; from these two counters and a set of programmed timing values it decodes horizontal sync, vertical sync and display-enable. It also brings the current pixel and line positions out so that downstream fetch logic can follow the raster.

Horizontal totals and active width are given in 8-pixel characters with a minus-one encoding. The horizontal sync position is given in pixels, while its width is given in characters. Vertical values are given in lines, also minus one. Sync widths of zero are widened to one unit, and each sync has its own polarity control. An optional double-scan mode emits every line twice. A power-state input gates the outputs. In any state other than running, the display is blanked. Standby and suspend each silence a different sync, and the off state silences both.

All timing inputs go into a shadow copy. The counters read only this copy. The copy is refreshed while the pipe is disabled and at the wrap from the last pixel of a frame to the first, so a value written mid-frame never tears the raster.

Top module: `crtc_timing_gen`

## Requirements
- R1: With total field HT, `pix_cnt_o` steps 0, 1, ... (HT+1)*8-1 and then returns to 0, one step per clock while enabled.
- R2: With vertical total VT, `line_cnt_o` steps 0 .. VT and then returns to 0, advancing in the cycle where `pix_cnt_o` returns to 0.
- R3: `de_o` is 1 exactly when the pixel lies below (HD+1)*8 and the line is at most VD, where HD and VD are the display fields, and only while the power state is running.
- R4: Horizontal sync is active for pixels P where S <= P < S + 8*W. Here S is the 12-bit start in pixels and W is the 6-bit width in characters, with a width of 0 taken as 1.
- R5: Vertical sync is active for lines L where V+1 <= L < V+1+N. Here V is the 12-bit start field and N is the 5-bit width in lines, with a width of 0 taken as 1.
- R6: A polarity input at 1 makes that sync output active-low, so its inactive level is 1. A polarity input at 0 makes the sync active-high.
- R7: With double-scan set, each line number is held for two full pixel passes, so a frame lasts 2*(VT+1) scan lines.
- R8: Power state 2'd1 (standby) holds `de_o` low and holds hsync at its inactive level, while vsync keeps running.
- R9: Power state 2'd2 (suspend) holds `de_o` low and holds vsync at its inactive level, while hsync keeps running.
- R10: Power state 2'd3 (off) holds `de_o` low and holds both syncs inactive. Power state 2'd0 (on) drives everything normally.
- R11: Timing inputs that change mid-frame take effect only from the first pixel of the next frame. The shadow copy reloads only at the frame wrap or while the pipe is disabled.
- R12: After reset, or one cycle after `crtc_en_i` goes low, both counters read 0, `de_o` is 0 and both syncs sit at their inactive level. Each output shows the state of the raster one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crtc_en_i | input | 1 | Enables the raster counters |
| pwr_state_i | input | 2 | 0 on, 1 standby, 2 suspend, 3 off |
| dbl_scan_i | input | 1 | Output each line twice |
| h_total_i | input | FW | Line length in characters minus one |
| h_disp_i | input | FW | Active width in characters minus one |
| h_sync_start_i | input | SW | Hsync start pixel |
| h_sync_wid_i | input | HWW | Hsync width in characters, 0 taken as 1 |
| h_sync_neg_i | input | 1 | Hsync active-low |
| v_total_i | input | FW | Frame length in lines minus one |
| v_disp_i | input | FW | Active height in lines minus one |
| v_sync_start_i | input | SW | Vsync start line minus one |
| v_sync_wid_i | input | VWW | Vsync width in lines, 0 taken as 1 |
| v_sync_neg_i | input | 1 | Vsync active-low |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| pix_cnt_o | output | FW+3 | Pixel position in line |
| line_cnt_o | output | FW | Line position in frame |

## Verification
The frame wrap, where the shadow copy reloads, can fall in the same cycle as a fresh timing write or a power-state change. The bench provokes this by rewriting totals, display sizes and double-scan partway through a frame, and by switching power states while frames run back to back. A cycle-accurate model in the bench predicts each output from the requirements and is checked against the design on every clock. A new value that lands one pixel early or late, or a sync that is gated in the wrong state, shows up as a miscompare in that cycle.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  typedef enum logic [1:0] {
    PWR_ON      = 2'd0,
    PWR_STANDBY = 2'd1,
    PWR_SUSPEND = 2'd2,
    PWR_OFF     = 2'd3
  } pwr_e;

  localparam int CHAR_SHIFT = 3;
endpackage

// File: rtl/crtc_h_axis.sv
module crtc_h_axis #(
  parameter int FW  = 16,
  parameter int SW  = 12,
  parameter int HWW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [FW-1:0]   total_i,
  input  logic [FW-1:0]   disp_i,
  input  logic [SW-1:0]   start_i,
  input  logic [HWW-1:0]  wid_i,
  output logic [FW+2:0]   px_o,
  output logic            last_o,
  output logic            de_o,
  output logic            act_o
);
  localparam int PW = FW + crtc_pkg::CHAR_SHIFT;
  localparam int EW = PW + 1;

  logic [PW-1:0]  px_q;
  logic [HWW-1:0] wid_eff;
  logic [EW-1:0]  start_x, stop_x, px_x;

  assign last_o = (px_q[PW-1:3] == total_i) && (&px_q[2:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     px_q <= '0;
    else if (clr_i)  px_q <= '0;
    else if (last_o) px_q <= '0;
    else             px_q <= px_q + 1'b1;
  end

  assign wid_eff = (wid_i == '0) ? HWW'(1) : wid_i;
  assign start_x = EW'(start_i);
  assign stop_x  = start_x + (EW'(wid_eff) << crtc_pkg::CHAR_SHIFT);
  assign px_x    = EW'(px_q);

  assign de_o  = (px_q[PW-1:3] <= disp_i);
  assign act_o = (px_x >= start_x) && (px_x < stop_x);
  assign px_o  = px_q;
endmodule

// File: rtl/crtc_v_axis.sv
module crtc_v_axis #(
  parameter int FW  = 16,
  parameter int SW  = 12,
  parameter int VWW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  input  logic            dbl_i,
  input  logic [FW-1:0]   total_i,
  input  logic [FW-1:0]   disp_i,
  input  logic [SW-1:0]   start_i,
  input  logic [VWW-1:0]  wid_i,
  output logic [FW-1:0]   ln_o,
  output logic            last_o,
  output logic            de_o,
  output logic            act_o
);
  localparam int EW = FW + 2;

  logic [FW-1:0]  ln_q;
  logic           scan_q;
  logic           line_done;
  logic [VWW-1:0] wid_eff;
  logic [EW-1:0]  start_x, stop_x, ln_x;

  // second pass of a doubled line, or any pass when single-scan
  assign line_done = adv_i && (!dbl_i || scan_q);
  assign last_o    = line_done && (ln_q == total_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ln_q   <= '0;
      scan_q <= 1'b0;
    end else if (clr_i) begin
      ln_q   <= '0;
      scan_q <= 1'b0;
    end else if (adv_i) begin
      if (dbl_i && !scan_q) begin
        scan_q <= 1'b1;
      end else begin
        scan_q <= 1'b0;
        ln_q   <= last_o ? '0 : ln_q + 1'b1;
      end
    end
  end

  assign wid_eff = (wid_i == '0) ? VWW'(1) : wid_i;
  assign start_x = EW'(start_i) + 1'b1;
  assign stop_x  = start_x + EW'(wid_eff);
  assign ln_x    = EW'(ln_q);

  assign de_o  = (ln_q <= disp_i);
  assign act_o = (ln_x >= start_x) && (ln_x < stop_x);
  assign ln_o  = ln_q;
endmodule

// File: rtl/crtc_out_stage.sv
module crtc_out_stage
  import crtc_pkg::*;
#(
  parameter int PW = 19,
  parameter int LW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [1:0]     pwr_i,
  input  logic           h_de_i,
  input  logic           v_de_i,
  input  logic           h_act_i,
  input  logic           v_act_i,
  input  logic           h_neg_i,
  input  logic           v_neg_i,
  input  logic [PW-1:0]  px_i,
  input  logic [LW-1:0]  ln_i,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic [PW-1:0]  px_o,
  output logic [LW-1:0]  ln_o
);
  pwr_e pwr;
  logic h_mute, v_mute, run;

  assign pwr    = pwr_e'(pwr_i);
  assign run    = (pwr == PWR_ON);
  assign h_mute = (pwr == PWR_STANDBY) || (pwr == PWR_OFF);
  assign v_mute = (pwr == PWR_SUSPEND) || (pwr == PWR_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      px_o    <= '0;
      ln_o    <= '0;
    end else begin
      hsync_o <= (valid_i && h_act_i && !h_mute) ^ h_neg_i;
      vsync_o <= (valid_i && v_act_i && !v_mute) ^ v_neg_i;
      de_o    <= valid_i && run && h_de_i && v_de_i;
      px_o    <= px_i;
      ln_o    <= ln_i;
    end
  end
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen #(
  parameter int FW  = 16,
  parameter int SW  = 12,
  parameter int HWW = 6,
  parameter int VWW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            crtc_en_i,
  input  logic [1:0]      pwr_state_i,
  input  logic            dbl_scan_i,
  input  logic [FW-1:0]   h_total_i,
  input  logic [FW-1:0]   h_disp_i,
  input  logic [SW-1:0]   h_sync_start_i,
  input  logic [HWW-1:0]  h_sync_wid_i,
  input  logic            h_sync_neg_i,
  input  logic [FW-1:0]   v_total_i,
  input  logic [FW-1:0]   v_disp_i,
  input  logic [SW-1:0]   v_sync_start_i,
  input  logic [VWW-1:0]  v_sync_wid_i,
  input  logic            v_sync_neg_i,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic [FW+2:0]   pix_cnt_o,
  output logic [FW-1:0]   line_cnt_o
);
  localparam int PW = FW + crtc_pkg::CHAR_SHIFT;

  logic [FW-1:0]  sh_h_total_q, sh_h_disp_q, sh_v_total_q, sh_v_disp_q;
  logic [SW-1:0]  sh_h_start_q, sh_v_start_q;
  logic [HWW-1:0] sh_h_wid_q;
  logic [VWW-1:0] sh_v_wid_q;
  logic           sh_h_neg_q, sh_v_neg_q, sh_dbl_q;
  logic           valid_q;

  logic           clr, h_last, frame_last, load;
  logic           h_de, v_de, h_act, v_act;
  logic [PW-1:0]  px_q;
  logic [FW-1:0]  ln_q;

  // counters held at zero while disabled and for the first enabled edge
  assign clr  = !crtc_en_i || !valid_q;
  assign load = !valid_q || frame_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= crtc_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_h_total_q <= '0;
      sh_h_disp_q  <= '0;
      sh_h_start_q <= '0;
      sh_h_wid_q   <= '0;
      sh_h_neg_q   <= 1'b0;
      sh_v_total_q <= '0;
      sh_v_disp_q  <= '0;
      sh_v_start_q <= '0;
      sh_v_wid_q   <= '0;
      sh_v_neg_q   <= 1'b0;
      sh_dbl_q     <= 1'b0;
    end else if (load) begin
      sh_h_total_q <= h_total_i;
      sh_h_disp_q  <= h_disp_i;
      sh_h_start_q <= h_sync_start_i;
      sh_h_wid_q   <= h_sync_wid_i;
      sh_h_neg_q   <= h_sync_neg_i;
      sh_v_total_q <= v_total_i;
      sh_v_disp_q  <= v_disp_i;
      sh_v_start_q <= v_sync_start_i;
      sh_v_wid_q   <= v_sync_wid_i;
      sh_v_neg_q   <= v_sync_neg_i;
      sh_dbl_q     <= dbl_scan_i;
    end
  end

  crtc_h_axis #(.FW(FW), .SW(SW), .HWW(HWW)) u_h (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .total_i (sh_h_total_q),
    .disp_i  (sh_h_disp_q),
    .start_i (sh_h_start_q),
    .wid_i   (sh_h_wid_q),
    .px_o    (px_q),
    .last_o  (h_last),
    .de_o    (h_de),
    .act_o   (h_act)
  );

  crtc_v_axis #(.FW(FW), .SW(SW), .VWW(VWW)) u_v (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .adv_i   (h_last),
    .dbl_i   (sh_dbl_q),
    .total_i (sh_v_total_q),
    .disp_i  (sh_v_disp_q),
    .start_i (sh_v_start_q),
    .wid_i   (sh_v_wid_q),
    .ln_o    (ln_q),
    .last_o  (frame_last),
    .de_o    (v_de),
    .act_o   (v_act)
  );

  crtc_out_stage #(.PW(PW), .LW(FW)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_q),
    .pwr_i   (pwr_state_i),
    .h_de_i  (h_de),
    .v_de_i  (v_de),
    .h_act_i (h_act),
    .v_act_i (v_act),
    .h_neg_i (sh_h_neg_q),
    .v_neg_i (sh_v_neg_q),
    .px_i    (px_q),
    .ln_i    (ln_q),
    .hsync_o (hsync_o),
    .vsync_o (vsync_o),
    .de_o    (de_o),
    .px_o    (pix_cnt_o),
    .ln_o    (line_cnt_o)
  );
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
  import crtc_pkg::*;
#(
  parameter int FW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      pwr_state_i,
  input logic            hsync_o,
  input logic            vsync_o,
  input logic            de_o,
  input logic [FW+2:0]   pix_cnt_o,
  input logic [FW-1:0]   line_cnt_o,
  input logic [FW-1:0]   sh_htotal_i,
  input logic [FW-1:0]   sh_hdisp_i,
  input logic [FW-1:0]   sh_vdisp_i,
  input logic            sh_hneg_i,
  input logic            sh_vneg_i,
  input logic [FW+2:0]   ctr_px_i
);
  localparam int PW = FW + CHAR_SHIFT;

  // R1
  pix_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_cnt_o != '0) |-> (pix_cnt_o == $past(pix_cnt_o) + 1'b1));

  // R2
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_cnt_o != '0) |-> $stable(line_cnt_o));

  // R3
  de_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> ((pix_cnt_o[PW-1:3] <= $past(sh_hdisp_i)) && (line_cnt_o <= $past(sh_vdisp_i))));

  // R8
  hsync_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwr_state_i == PWR_STANDBY) || (pwr_state_i == PWR_OFF)) |=> (hsync_o == $past(sh_hneg_i)));

  // R9
  vsync_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwr_state_i == PWR_SUSPEND) || (pwr_state_i == PWR_OFF)) |=> (vsync_o == $past(sh_vneg_i)));

  // R10
  blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_i != PWR_ON) |=> !de_o);

  // R11
  shadow_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sh_htotal_i) |-> (ctr_px_i == '0));
endmodule

bind crtc_timing_gen crtc_timing_chk #(.FW(FW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_state_i (pwr_state_i),
  .hsync_o     (hsync_o),
  .vsync_o     (vsync_o),
  .de_o        (de_o),
  .pix_cnt_o   (pix_cnt_o),
  .line_cnt_o  (line_cnt_o),
  .sh_htotal_i (sh_h_total_q),
  .sh_hdisp_i  (sh_h_disp_q),
  .sh_vdisp_i  (sh_v_disp_q),
  .sh_hneg_i   (sh_h_neg_q),
  .sh_vneg_i   (sh_v_neg_q),
  .ctr_px_i    (px_q)
);

// File: tb/sim_crtc_timing_gen.sv
`timescale 1ns/1ps
module sim_crtc_timing_gen;
  localparam int FW = 16;
  localparam int SW = 12;
  localparam int HWW = 6;
  localparam int VWW = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic crtc_en_i = 1'b0;
  logic [1:0] pwr_state_i = 2'd0;
  logic dbl_scan_i = 1'b0;
  logic [FW-1:0] h_total_i = '0, h_disp_i = '0, v_total_i = '0, v_disp_i = '0;
  logic [SW-1:0] h_sync_start_i = '0, v_sync_start_i = '0;
  logic [HWW-1:0] h_sync_wid_i = '0;
  logic [VWW-1:0] v_sync_wid_i = '0;
  logic h_sync_neg_i = 1'b0, v_sync_neg_i = 1'b0;
  logic hsync_o, vsync_o, de_o;
  logic [FW+2:0] pix_cnt_o;
  logic [FW-1:0] line_cnt_o;

  always #2.5 clk_i = ~clk_i;

  crtc_timing_gen #(.FW(FW), .SW(SW), .HWW(HWW), .VWW(VWW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .crtc_en_i(crtc_en_i), .pwr_state_i(pwr_state_i),
    .dbl_scan_i(dbl_scan_i), .h_total_i(h_total_i), .h_disp_i(h_disp_i),
    .h_sync_start_i(h_sync_start_i), .h_sync_wid_i(h_sync_wid_i), .h_sync_neg_i(h_sync_neg_i),
    .v_total_i(v_total_i), .v_disp_i(v_disp_i), .v_sync_start_i(v_sync_start_i),
    .v_sync_wid_i(v_sync_wid_i), .v_sync_neg_i(v_sync_neg_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_cnt_o(pix_cnt_o), .line_cnt_o(line_cnt_o));

  typedef struct {
    bit hs, vs, de;
    int px, ln;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  string tag = "R12";
  bit done = 0;

  // reference model state
  int m_px, m_ln, m_scan, m_valid;
  int s_ht, s_hd, s_hs, s_hw, s_hn, s_vt, s_vd, s_vs, s_vw, s_vn, s_dbl;
  int hw, vw, last_px, vlast, fl, ld, pw;
  bit ha, va, dd;

  always @(posedge clk_i) begin
    exp_t e;
    cyc++;
    if (!rst_ni) begin
      e = '{0, 0, 0, 0, 0};
      m_px = 0; m_ln = 0; m_scan = 0; m_valid = 0;
      s_ht = 0; s_hd = 0; s_hs = 0; s_hw = 0; s_hn = 0;
      s_vt = 0; s_vd = 0; s_vs = 0; s_vw = 0; s_vn = 0; s_dbl = 0;
    end else begin
      pw = int'(pwr_state_i);
      hw = (s_hw == 0) ? 1 : s_hw;
      vw = (s_vw == 0) ? 1 : s_vw;
      ha = m_valid != 0 && m_px >= s_hs && m_px < s_hs + hw * 8;
      va = m_valid != 0 && m_ln >= s_vs + 1 && m_ln < s_vs + 1 + vw;
      dd = m_valid != 0 && pw == 0 && (m_px / 8) <= s_hd && m_ln <= s_vd;
      if (pw == 1 || pw == 3) ha = 0;
      if (pw == 2 || pw == 3) va = 0;
      e.hs = ha ^ bit'(s_hn);
      e.vs = va ^ bit'(s_vn);
      e.de = dd;
      e.px = m_px;
      e.ln = m_ln;
      last_px = (m_px == (s_ht + 1) * 8 - 1) ? 1 : 0;
      vlast = (m_ln == s_vt && (s_dbl == 0 || m_scan != 0)) ? 1 : 0;
      fl = last_px & vlast;
      ld = (m_valid == 0 || fl != 0) ? 1 : 0;
      if (!crtc_en_i || m_valid == 0) begin
        m_px = 0; m_ln = 0; m_scan = 0;
      end else if (last_px != 0) begin
        m_px = 0;
        if (s_dbl != 0 && m_scan == 0) m_scan = 1;
        else begin
          m_scan = 0;
          m_ln = (m_ln == s_vt) ? 0 : m_ln + 1;
        end
      end else m_px = m_px + 1;
      if (ld != 0) begin
        s_ht = int'(h_total_i); s_hd = int'(h_disp_i); s_hs = int'(h_sync_start_i);
        s_hw = int'(h_sync_wid_i); s_hn = int'(h_sync_neg_i);
        s_vt = int'(v_total_i); s_vd = int'(v_disp_i); s_vs = int'(v_sync_start_i);
        s_vw = int'(v_sync_wid_i); s_vn = int'(v_sync_neg_i); s_dbl = int'(dbl_scan_i);
      end
      m_valid = crtc_en_i ? 1 : 0;
    end
    q.push_back(e);
  end

  // monitor: compare away from the active edge
  always @(negedge clk_i) begin
    exp_t e;
    bit bad;
    if (q.size() > 0 && !done) begin
      e = q.pop_front();
      bad = 0;
      n_chk++;
      if (int'(pix_cnt_o) != e.px) begin
        bad = 1;
        $display("FAIL %s R1 pix_cnt got %0d exp %0d", tag, pix_cnt_o, e.px);
      end
      if (int'(line_cnt_o) != e.ln) begin
        bad = 1;
        $display("FAIL %s R2 line_cnt got %0d exp %0d", tag, line_cnt_o, e.ln);
      end
      if (de_o != e.de) begin
        bad = 1;
        $display("FAIL %s R3 de got %0b exp %0b", tag, de_o, e.de);
      end
      if (hsync_o != e.hs) begin
        bad = 1;
        $display("FAIL %s R4 hsync got %0b exp %0b", tag, hsync_o, e.hs);
      end
      if (vsync_o != e.vs) begin
        bad = 1;
        $display("FAIL %s R5 vsync got %0b exp %0b", tag, vsync_o, e.vs);
      end
      if (bad) n_bad++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic base_cfg();
    h_total_i = 16'd3; h_disp_i = 16'd1; h_sync_start_i = 12'd20; h_sync_wid_i = 6'd1;
    v_total_i = 16'd5; v_disp_i = 16'd3; v_sync_start_i = 12'd3; v_sync_wid_i = 5'd1;
    h_sync_neg_i = 1'b0; v_sync_neg_i = 1'b0; dbl_scan_i = 1'b0;
  endtask

  localparam int FR = 192;

  initial begin
    base_cfg();
    tick(4);
    // R12 reset state
    tag = "R12";
    rst_ni = 1'b1;
    tick(5);
    tag = "R1 R2 R3";
    crtc_en_i = 1'b1;
    tick(2 * FR + 10);
    // R4 R5 zero widths are widened to one unit
    tag = "R4 R5 zero-width";
    h_sync_wid_i = '0; v_sync_wid_i = '0;
    tick(2 * FR + 5);
    tag = "R4 R5 max-width";
    h_sync_wid_i = 6'd63; v_sync_wid_i = 5'd31; h_sync_start_i = 12'd4; v_sync_start_i = 12'd1;
    tick(2 * FR);
    base_cfg();
    tag = "R6";
    h_sync_neg_i = 1'b1; v_sync_neg_i = 1'b1;
    tick(2 * FR);
    tag = "R7";
    dbl_scan_i = 1'b1;
    tick(4 * FR + 5);
    dbl_scan_i = 1'b0;
    tick(2 * FR);
    tag = "R8";
    pwr_state_i = 2'd1;
    tick(FR + 7);
    tag = "R9";
    pwr_state_i = 2'd2;
    tick(FR + 3);
    tag = "R10";
    pwr_state_i = 2'd3;
    tick(FR);
    pwr_state_i = 2'd0;
    tick(FR);
    // R11 mid-frame writes wait for the wrap
    tag = "R11";
    tick(37);
    h_total_i = 16'd4; h_disp_i = 16'd2; v_total_i = 16'd6; v_disp_i = 16'd4; dbl_scan_i = 1'b1;
    tick(700);
    h_total_i = 16'd2; v_sync_start_i = 12'd0;
    tick(500);
    tag = "R12 disable";
    crtc_en_i = 1'b0;
    tick(20);
    crtc_en_i = 1'b1;
    tick(120);
    tag = "R12 reset";
    rst_ni = 1'b0;
    tick(3);
    rst_ni = 1'b1;
    tick(60);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog R12 got %0d cycles exp completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule